// File: doc/BRIEF.md
# Counter CSR Read Permission Checker

This block decides, in a single combinational pass, whether an instruction that reads a user-level counter CSR may proceed. It handles the fixed counters (cycle, time, retired instructions) and the performance counters at indices 3 to 31. On a 32-bit core it also handles the aliases that return the upper halves of those counters. The CSR address is turned into a counter index. A one-hot mask built from that index picks the matching bit out of the machine, supervisor and hypervisor enable words and out of the availability bitmap.

The checks run in a fixed order, and the first one that fails decides the outcome. The address window comes first, then performance-counter availability, then the enable check for the current privilege level, then the guest checks that apply while virtualization is active. A failure in the first three stages reports an illegal instruction. A failure in the last stage reports a virtual-instruction fault. The block sits in the CSR read path of the decode stage, next to the trap logic, and holds no state.

Top module: `ctr_access_checker`

## Requirements
- R1: Addresses 0xC00 to 0xC1F select counter index address minus 0xC00. On an RV32 core (`is_rv32`=1), addresses 0xC80 to 0xC9F select index address minus 0xC80. Every other address gives `illegal_inst`.
- R2: On an RV64 core (`is_rv32`=0), addresses 0xC80 to 0xC9F give `illegal_inst`.
- R3: Indices 0, 1 and 2 (cycle, time, instret) are never refused because of `hpm_count` or `avail_map`.
- R4: For indices 3 to 31, the access gives `illegal_inst` when `hpm_count` is zero or when bit index of `avail_map` is clear.
- R5: At supervisor privilege (`priv`=2'b01), the access gives `illegal_inst` when bit index of `mcounteren` is clear.
- R6: At user privilege (`priv`=2'b00), the access gives `illegal_inst` when bit index of `mcounteren` or bit index of `scounteren` is clear.
- R7: With `virt_en`=1 at user or supervisor privilege, an access that passes R1 to R6 gives `virt_fault` when bit index of `mcounteren` or bit index of `hcounteren` is clear.
- R8: At machine privilege (`priv`=2'b11), none of the enable words and not `virt_en` affects the result. R1 to R4 still apply.
- R9: The first failing check wins, in this order: address window, availability, privilege enable, virtualization. An access that fails none of them gives `allow`.
- R10: The reserved privilege code 2'b10 gives `illegal_inst`.
- R11: For every input combination, exactly one of `allow`, `illegal_inst` and `virt_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | CSR address being read |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| virt_en | input | 1 | Virtualization active |
| is_rv32 | input | 1 | 1 for a 32-bit core, 0 for a 64-bit core |
| mcounteren | input | 32 | Machine counter-enable word |
| hcounteren | input | 32 | Hypervisor counter-enable word |
| scounteren | input | 32 | Supervisor counter-enable word |
| hpm_count | input | 5 | Number of implemented performance counters |
| avail_map | input | 32 | Bitmap of available counters |
| allow | output | 1 | Read permitted |
| illegal_inst | output | 1 | Read raises an illegal-instruction exception |
| virt_fault | output | 1 | Read raises a virtual-instruction fault |

## Verification
Every result is combinational, so it is due in the same cycle as its stimulus, with zero register stages on the way. The bench applies each input vector on a falling clock edge and samples the three outputs one nanosecond after the next rising edge. By then the inputs have been stable for half a period, and no sample falls on an edge. The sweep covers each address around both counter windows, each privilege code, both core widths and both virtualization states, under several enable and availability patterns. The expected verdict is computed from the ordered rules.

// File: rtl/ctr_chk_pkg.sv
// Package: shared encodings for the counter access checker.
// Assumes the standard two-bit privilege encoding; 2'b10 is reserved.
package ctr_chk_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        VERDICT_ALLOW   = 2'b00,
        VERDICT_ILLEGAL = 2'b01,
        VERDICT_VFAULT  = 2'b10
    } verdict_e;

endpackage

// File: rtl/ctr_addr_decode.sv
// Module: ctr_addr_decode
// Maps a CSR address to a counter index and a one-hot selection mask.
// The low window starts at BASE_LO. On a 32-bit core a second window,
// HI_OFFSET above it, aliases the upper counter halves.
// Assumes NUM_CTR is a power of two no larger than 2**ADDR_W.
module ctr_addr_decode #(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_CTR   = 32,
    parameter int          NUM_FIXED = 3,
    parameter logic [11:0] BASE_LO   = 12'hC00,
    parameter logic [11:0] HI_OFFSET = 12'h080,
    localparam int         IDX_W     = $clog2(NUM_CTR)
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               rv32_i,
    output logic               hit_o,
    output logic               fixed_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [NUM_CTR-1:0] mask_o
);

    localparam logic [ADDR_W-1:0] LO_BASE = ADDR_W'(BASE_LO);
    localparam logic [ADDR_W-1:0] HI_BASE = ADDR_W'(BASE_LO + HI_OFFSET);
    localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(NUM_CTR);

    logic [ADDR_W-1:0] lo_off;
    logic [ADDR_W-1:0] hi_off;
    logic              in_lo;
    logic              in_hi;

    // Offsets of the address from both window bases and membership tests.
    always_comb begin
        lo_off = addr_i - LO_BASE;
        hi_off = addr_i - HI_BASE;
        in_lo  = (lo_off < SPAN);
        in_hi  = (hi_off < SPAN) && rv32_i;
    end

    // Index selection; the upper window is used only when it matched.
    always_comb begin
        hit_o   = in_lo || in_hi;
        idx_o   = in_hi ? hi_off[IDX_W-1:0] : lo_off[IDX_W-1:0];
        fixed_o = (int'(idx_o) < NUM_FIXED);
    end

    // One-hot mask, one bit per counter slot.
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_mask
        assign mask_o[g] = hit_o && (idx_o == IDX_W'(g));
    end

    // R1: a hit yields a single selected slot, a miss selects nothing.
    always_comb begin
        p_mask_onehot_r1: assert ($countones(mask_o) == (hit_o ? 1 : 0))
            else $error("decode mask population wrong");
    end

endmodule

// File: rtl/ctr_avail_check.sv
// Module: ctr_avail_check
// Decides whether the selected counter is implemented. Fixed counters
// always pass. Performance counters need a nonzero implemented count
// and their bit set in the availability bitmap.
// Assumes sel_i is one-hot or zero.
module ctr_avail_check #(
    parameter int NUM_CTR = 32,
    parameter int CNT_W   = 5
) (
    input  logic               fixed_i,
    input  logic [NUM_CTR-1:0] sel_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [NUM_CTR-1:0] map_i,
    output logic               ok_o
);

    logic any_impl;
    logic bit_set;

    // Gather the two availability conditions for performance counters.
    always_comb begin
        any_impl = (count_i != '0);
        bit_set  = |(map_i & sel_i);
    end

    // Fixed counters bypass the availability test altogether.
    always_comb begin
        ok_o = fixed_i || (any_impl && bit_set);
    end

    // R3: fixed counters are never refused here.
    always_comb begin
        p_fixed_pass_r3: assert (!fixed_i || ok_o)
            else $error("fixed counter refused by availability");
    end

    // R4: a zero implemented count refuses every non-fixed counter.
    always_comb begin
        p_zero_count_r4: assert (fixed_i || any_impl || !ok_o)
            else $error("counter passed with zero implemented count");
    end

endmodule

// File: rtl/ctr_priv_check.sv
// Module: ctr_priv_check
// Applies the counter-enable words for the current privilege level and
// the guest checks that apply while virtualization is active.
// Assumes sel_i is one-hot or zero. Machine level bypasses every enable.
module ctr_priv_check
    import ctr_chk_pkg::*;
#(
    parameter int NUM_CTR = 32
) (
    input  priv_e              priv_i,
    input  logic               virt_i,
    input  logic [NUM_CTR-1:0] sel_i,
    input  logic [NUM_CTR-1:0] m_en_i,
    input  logic [NUM_CTR-1:0] s_en_i,
    input  logic [NUM_CTR-1:0] h_en_i,
    output logic               level_ok_o,
    output logic               guest_ok_o
);

    logic m_bit;
    logic s_bit;
    logic h_bit;

    // Pick the selected counter's bit out of each enable word.
    always_comb begin
        m_bit = |(m_en_i & sel_i);
        s_bit = |(s_en_i & sel_i);
        h_bit = |(h_en_i & sel_i);
    end

    // Privilege-level enable check; the reserved code always fails.
    always_comb begin
        unique case (priv_i)
            PRIV_MACH:  level_ok_o = 1'b1;
            PRIV_SUPER: level_ok_o = m_bit;
            PRIV_USER:  level_ok_o = m_bit && s_bit;
            default:    level_ok_o = 1'b0;
        endcase
    end

    // Guest check: both machine and hypervisor bits are needed in a guest.
    always_comb begin
        guest_ok_o = (priv_i == PRIV_MACH) || !virt_i || (m_bit && h_bit);
    end

    // R8: machine level never fails either stage.
    always_comb begin
        p_mach_free_r8: assert (priv_i != PRIV_MACH || (level_ok_o && guest_ok_o))
            else $error("machine access refused by enables");
    end

endmodule

// File: rtl/ctr_access_checker.sv
// Module: ctr_access_checker (top)
// Combinational permission check for reads of user counter CSRs.
// Chains address decode, availability and enable checks. The first
// failing stage decides between an illegal-instruction and a
// virtual-instruction fault. Assumes the enable words and the bitmap
// share bit positions with counter indices.
module ctr_access_checker
    import ctr_chk_pkg::*;
#(
    parameter int NUM_CTR   = 32,
    parameter int NUM_FIXED = 3,
    parameter int ADDR_W    = 12,
    parameter int CNT_W     = 5,
    localparam int IDX_W    = $clog2(NUM_CTR)
) (
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [1:0]         priv,
    input  logic               virt_en,
    input  logic               is_rv32,
    input  logic [NUM_CTR-1:0] mcounteren,
    input  logic [NUM_CTR-1:0] hcounteren,
    input  logic [NUM_CTR-1:0] scounteren,
    input  logic [CNT_W-1:0]   hpm_count,
    input  logic [NUM_CTR-1:0] avail_map,
    output logic               allow,
    output logic               illegal_inst,
    output logic               virt_fault
);

    logic               hit;
    logic               fixed;
    logic [IDX_W-1:0]   idx;
    logic [NUM_CTR-1:0] sel;
    logic               avail_ok;
    logic               level_ok;
    logic               guest_ok;
    priv_e              priv_q;
    verdict_e           verdict;

    // Cast the raw privilege code into the shared enum.
    always_comb priv_q = priv_e'(priv);

    ctr_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CTR   (NUM_CTR),
        .NUM_FIXED (NUM_FIXED)
    ) i_decode (
        .addr_i  (csr_addr),
        .rv32_i  (is_rv32),
        .hit_o   (hit),
        .fixed_o (fixed),
        .idx_o   (idx),
        .mask_o  (sel)
    );

    ctr_avail_check #(
        .NUM_CTR (NUM_CTR),
        .CNT_W   (CNT_W)
    ) i_avail (
        .fixed_i (fixed),
        .sel_i   (sel),
        .count_i (hpm_count),
        .map_i   (avail_map),
        .ok_o    (avail_ok)
    );

    ctr_priv_check #(
        .NUM_CTR (NUM_CTR)
    ) i_priv (
        .priv_i     (priv_q),
        .virt_i     (virt_en),
        .sel_i      (sel),
        .m_en_i     (mcounteren),
        .s_en_i     (scounteren),
        .h_en_i     (hcounteren),
        .level_ok_o (level_ok),
        .guest_ok_o (guest_ok)
    );

    // Ordered resolution: window, availability, privilege, guest (R9).
    always_comb begin
        if (!hit || !avail_ok)  verdict = VERDICT_ILLEGAL;
        else if (!level_ok)     verdict = VERDICT_ILLEGAL;
        else if (!guest_ok)     verdict = VERDICT_VFAULT;
        else                    verdict = VERDICT_ALLOW;
    end

    // Decode the verdict onto the three output flags.
    always_comb begin
        allow        = (verdict == VERDICT_ALLOW);
        illegal_inst = (verdict == VERDICT_ILLEGAL);
        virt_fault   = (verdict == VERDICT_VFAULT);
    end

    // Output-level properties, evaluated on every input change.
    always_comb begin
        // R11: exactly one flag raised.
        p_one_flag_r11: assert ($countones({allow, illegal_inst, virt_fault}) == 1)
            else $error("output flags not one-hot");
        // R7: a guest fault needs virtualization below machine level.
        p_vfault_guest_r7: assert (!virt_fault || (virt_en && priv != 2'b11))
            else $error("virtual fault outside a guest");
        // R2: upper aliases on a 64-bit core are never allowed.
        p_rv64_upper_r2: assert (!(allow && !is_rv32 && csr_addr[7]))
            else $error("upper alias allowed on 64-bit core");
        // R10: reserved privilege never allowed.
        p_rsvd_priv_r10: assert (priv != 2'b10 || illegal_inst)
            else $error("reserved privilege not refused");
        // R1: allow only inside a counter window.
        p_allow_hit_r1: assert (!allow || hit)
            else $error("allow outside counter windows");
    end

endmodule

// File: tb/test_ctr_access_checker.sv
// Bench: sweeps addresses around both windows for each privilege code,
// core width, virtualization state and enable pattern. The expected
// verdict is computed from the ordered rules.
module test_ctr_access_checker;

    logic        clk = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  priv = '0;
    logic        virt_en = 1'b0;
    logic        is_rv32 = 1'b0;
    logic [31:0] mcounteren = '0;
    logic [31:0] hcounteren = '0;
    logic [31:0] scounteren = '0;
    logic [4:0]  hpm_count = '0;
    logic [31:0] avail_map = '0;
    logic        allow;
    logic        illegal_inst;
    logic        virt_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    ctr_access_checker i_ctr_access_checker (
        .csr_addr     (csr_addr),
        .priv         (priv),
        .virt_en      (virt_en),
        .is_rv32      (is_rv32),
        .mcounteren   (mcounteren),
        .hcounteren   (hcounteren),
        .scounteren   (scounteren),
        .hpm_count    (hpm_count),
        .avail_map    (avail_map),
        .allow        (allow),
        .illegal_inst (illegal_inst),
        .virt_fault   (virt_fault)
    );

    // Expected flags {allow, illegal, vfault} and the deciding requirement.
    function automatic void model(output logic [2:0] exp_f, output string tag);
        int  idx;
        bit  mb, sb, hb;
        int  a;
        a   = int'(csr_addr);
        idx = 0;
        if (priv == 2'b10) begin
            exp_f = 3'b010; tag = "R10"; return;
        end
        if (a >= 'hC00 && a < 'hC20) idx = a - 'hC00;
        else if (a >= 'hC80 && a < 'hCA0) begin
            if (!is_rv32) begin exp_f = 3'b010; tag = "R2"; return; end
            idx = a - 'hC80;
        end else begin
            exp_f = 3'b010; tag = "R1"; return;
        end
        if (idx >= 3 && (hpm_count == 0 || !avail_map[idx])) begin
            exp_f = 3'b010; tag = "R4"; return;
        end
        mb = mcounteren[idx]; sb = scounteren[idx]; hb = hcounteren[idx];
        if (priv == 2'b11) begin
            exp_f = 3'b100; tag = (idx < 3) ? "R3" : "R8"; return;
        end
        if (priv == 2'b01 && !mb) begin exp_f = 3'b010; tag = "R5"; return; end
        if (priv == 2'b00 && !(mb && sb)) begin exp_f = 3'b010; tag = "R6"; return; end
        if (virt_en && !(mb && hb)) begin exp_f = 3'b001; tag = "R7"; return; end
        exp_f = 3'b100;
        tag   = (idx < 3) ? "R3" : "R9";
    endfunction

    task automatic check_now();
        logic [2:0] exp_f;
        logic [2:0] got;
        string      tag;
        model(exp_f, tag);
        got = {allow, illegal_inst, virt_fault};
        n_checks++;
        if (got !== exp_f) begin
            n_fail++;
            $display("FAIL %s addr=%h priv=%b virt=%b rv32=%b got=%b expected=%b",
                     tag, csr_addr, priv, virt_en, is_rv32, got, exp_f);
        end
        n_checks++;
        if ($countones(got) != 1) begin   // R11
            n_fail++;
            $display("FAIL R11 addr=%h flags got=%b expected one-hot", csr_addr, got);
        end
    endtask

    task automatic set_pattern(input int p);
        case (p)
            0: begin mcounteren = '1; scounteren = '1; hcounteren = '1;
                     hpm_count = 5'd29; avail_map = '1; end
            1: begin mcounteren = 32'h5555_5555; scounteren = 32'hFFFF_0FFF;
                     hcounteren = 32'h0F0F_0F0F; hpm_count = 5'd8; avail_map = 32'h00FF_F0F7; end
            2: begin mcounteren = '0; scounteren = '1; hcounteren = '1;
                     hpm_count = 5'd0; avail_map = '1; end
            3: begin mcounteren = 32'hFFFF_FFF8; scounteren = 32'h3333_3333;
                     hcounteren = 32'hFFFF_0000; hpm_count = 5'd29; avail_map = 32'h0000_0000; end
            4: begin mcounteren = 32'h0000_0007; scounteren = 32'h0000_0005;
                     hcounteren = 32'h0000_0003; hpm_count = 5'd1; avail_map = 32'hAAAA_AAAA; end
            default: begin mcounteren = 32'hC3A5_96E1; scounteren = 32'h7E81_BD42;
                     hcounteren = 32'hF00F_5AA5; hpm_count = 5'd17; avail_map = 32'h9C63_E71F; end
        endcase
    endtask

    initial begin
        // Reset-state check: all-zero inputs, address 0 lies outside (R1).
        @(posedge clk); #1;
        check_now();
        for (int p = 0; p < 6; p++) begin
            for (int rv = 0; rv < 2; rv++) begin
                for (int pr = 0; pr < 4; pr++) begin
                    for (int v = 0; v < 2; v++) begin
                        for (int a = 'hBF8; a < 'hCA8; a++) begin
                            @(negedge clk);
                            set_pattern(p);
                            is_rv32  = rv[0];
                            priv     = pr[1:0];
                            virt_en  = v[0];
                            csr_addr = a[11:0];
                            @(posedge clk); #1;
                            check_now();
                        end
                    end
                end
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired before sweep completed");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule